// File: doc/BRIEF.md
# Dual-Stream Event Frame Serializer

The serializer takes one event that the capture stage has stored and sends it out as serial bit streams, one bit per clock. An event has two parts. The timing part is one wide word for each of nine channels. The charge part is a run of narrow samples for each channel. The serializer fetches words from the capture storage through two combinational read ports, one for timing and one for charge. Each read port gives a channel index (and, for charge, a sample index), and the storage returns the addressed word in the same cycle.

The serializer has two modes. In combined mode, stream A carries a single frame: all timing bits, then all charge bits, with no gap. In split mode, stream A carries only the short timing frame and stream B carries the long charge frame, and both frames start on the same cycle. With this split, the timing data is sent long before the charge data is finished. Each stream has a frame-valid strobe and a start-of-frame strobe. A busy flag tells the capture stage that the stored event is still being read. The mode input is taken only when an event is accepted.

Top module: `evt_frame_ser`

## Requirements
- R1: While reset is asserted, busy, both valid strobes, both start-of-frame strobes and both data outputs are 0.
- R2: A timing frame sends the timing words in channel order 0 to N_CH-1. Each word is sent most significant bit first, for N_CH*T_W bits.
- R3: A charge frame is sample-major. All N_CH channels of sample 0, in channel order, are sent before any channel of sample 1. Each sample is sent most significant bit first, for N_SMP*N_CH*C_W bits.
- R4: Combined mode is mode_split=0. Stream A sends the timing frame and then, with no gap, the charge frame, as one frame of N_CH*T_W + N_SMP*N_CH*C_W bits with one start-of-frame strobe. Stream B stays idle.
- R5: Split mode is mode_split=1. Stream A sends only the timing frame and stream B sends only the charge frame. Both start-of-frame strobes occur on the same cycle.
- R6: Valid is high on a stream for exactly the number of cycles in its frame, with no gaps. Start-of-frame is high for one cycle, on the first bit of the frame.
- R7: An event is accepted at a clock edge where busy is low and evt_ready is high. From the next cycle on, busy is high and the first bits are on the outputs. Busy falls in the cycle after the last bit of the longest frame.
- R8: evt_ready has no effect while busy is high. No extra frame starts, and busy still falls after the current event.
- R9: mode_split is sampled only at acceptance. Changing it during a frame does not change the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_ready | input | 1 | Capture stage holds a complete event |
| mode_split | input | 1 | 1 = split streams, 0 = combined stream |
| busy | output | 1 | Event is being read out |
| t_rd_ch | output | ceil(log2 N_CH) | Timing read port channel index |
| t_rd_data | input | T_W | Timing word for t_rd_ch, same cycle |
| c_rd_ch | output | ceil(log2 N_CH) | Charge read port channel index |
| c_rd_smp | output | ceil(log2 N_SMP) | Charge read port sample index |
| c_rd_data | input | C_W | Charge sample for the indices, same cycle |
| a_sdata | output | 1 | Stream A serial data |
| a_valid | output | 1 | Stream A frame valid |
| a_sof | output | 1 | Stream A start of frame |
| b_sdata | output | 1 | Stream B serial data |
| b_valid | output | 1 | Stream B frame valid |
| b_sof | output | 1 | Stream B start of frame |

## Verification
The clock edge that samples evt_ready is the acceptance edge. The first bit, both start-of-frame strobes and the rising edge of busy all appear in the cycle right after that edge. Bit k of a frame is on the outputs k cycles after the first bit. Busy falls one cycle after the final bit. The bench raises evt_ready at a falling edge, drops it at the next falling edge, and from then on samples every falling edge. At each sample it compares the bit with a model bit taken from the frame position index. It also counts valid, start-of-frame and busy cycles over a window longer than the frame, so any late, early or extra bit shows up as a length error.

// File: rtl/evt_ser_pkg.sv
package evt_ser_pkg;

    // Mode encoding latched at event acceptance.
    typedef enum logic {
        MODE_COMBINED = 1'b0,
        MODE_SPLIT    = 1'b1
    } frame_mode_e;

    // Index width for a counter over n positions, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ser_walker.sv
// Walks outer index, inner index and bit position of a frame made of
// OUTER_N x INNER_N words of WORD_W bits; bits descend (MSB first).
module ser_walker #(
    parameter  int OUTER_N = 1,
    parameter  int INNER_N = 9,
    parameter  int WORD_W  = 51,
    localparam int OW      = evt_ser_pkg::idx_w(OUTER_N),
    localparam int IW      = evt_ser_pkg::idx_w(INNER_N),
    localparam int BW      = evt_ser_pkg::idx_w(WORD_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          active,
    output logic          first,
    output logic          last,
    output logic [OW-1:0] outer_idx,
    output logic [IW-1:0] inner_idx,
    output logic [BW-1:0] bit_idx
);

    typedef struct packed {
        logic          act;
        logic          first;
        logic [OW-1:0] outer;
        logic [IW-1:0] inner;
        logic [BW-1:0] bitc;
    } walk_t;

    walk_t s_d, s_q;

    logic word_end, inner_end, outer_end;

    assign word_end  = (s_q.bitc  == '0);
    assign inner_end = (s_q.inner == IW'(INNER_N - 1));
    assign outer_end = (s_q.outer == OW'(OUTER_N - 1));

    always_comb begin
        s_d       = s_q;
        s_d.first = 1'b0;
        if (!s_q.act) begin
            if (start) begin
                s_d.act   = 1'b1;
                s_d.first = 1'b1;
                s_d.outer = '0;
                s_d.inner = '0;
                s_d.bitc  = BW'(WORD_W - 1);
            end
        end else if (word_end) begin
            s_d.bitc = BW'(WORD_W - 1);
            if (inner_end) begin
                s_d.inner = '0;
                if (outer_end) begin
                    s_d.act   = 1'b0;
                    s_d.outer = '0;
                end else begin
                    s_d.outer = s_q.outer + 1'b1;
                end
            end else begin
                s_d.inner = s_q.inner + 1'b1;
            end
        end else begin
            s_d.bitc = s_q.bitc - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active    = s_q.act;
    assign first     = s_q.first;
    assign last      = s_q.act && word_end && inner_end && outer_end;
    assign outer_idx = s_q.outer;
    assign inner_idx = s_q.inner;
    assign bit_idx   = s_q.bitc;

endmodule

// File: rtl/stream_route.sv
// Maps the timing and charge walkers onto the two serial outputs.
module stream_route (
    input  logic split,
    input  logic t_act,
    input  logic t_first,
    input  logic t_bit,
    input  logic c_act,
    input  logic c_first,
    input  logic c_bit,
    output logic a_sdata,
    output logic a_valid,
    output logic a_sof,
    output logic b_sdata,
    output logic b_valid,
    output logic b_sof
);

    always_comb begin
        a_sof   = t_first;
        a_valid = split ? t_act : (t_act || c_act);
        if (t_act)               a_sdata = t_bit;
        else if (!split && c_act) a_sdata = c_bit;
        else                     a_sdata = 1'b0;
        b_valid = split && c_act;
        b_sof   = split && c_first;
        b_sdata = split && c_act && c_bit;
    end

endmodule

// File: rtl/evt_frame_ser.sv
module evt_frame_ser #(
    parameter  int N_CH  = 9,
    parameter  int T_W   = 51,
    parameter  int C_W   = 12,
    parameter  int N_SMP = 200,
    localparam int CHW   = evt_ser_pkg::idx_w(N_CH),
    localparam int SW    = evt_ser_pkg::idx_w(N_SMP),
    localparam int TBW   = evt_ser_pkg::idx_w(T_W),
    localparam int CBW   = evt_ser_pkg::idx_w(C_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_ready,
    input  logic             mode_split,
    output logic             busy,
    output logic [CHW-1:0]   t_rd_ch,
    input  logic [T_W-1:0]   t_rd_data,
    output logic [CHW-1:0]   c_rd_ch,
    output logic [SW-1:0]    c_rd_smp,
    input  logic [C_W-1:0]   c_rd_data,
    output logic             a_sdata,
    output logic             a_valid,
    output logic             a_sof,
    output logic             b_sdata,
    output logic             b_valid,
    output logic             b_sof
);
    import evt_ser_pkg::*;

    typedef struct packed {
        logic        busy;
        frame_mode_e mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic           t_act, t_first, t_last, t_start;
    logic [0:0]     t_outer;
    logic [TBW-1:0] t_bitc;
    logic           c_act, c_first, c_last, c_start;
    logic [CBW-1:0] c_bitc;
    logic           accept, done, split_q;

    assign accept  = !ctl_q.busy && evt_ready;
    assign split_q = (ctl_q.mode == MODE_SPLIT);
    assign t_start = accept;
    assign c_start = (accept && mode_split) ||
                     (ctl_q.busy && !split_q && t_last);

    always_comb begin
        if (!ctl_q.busy)  done = 1'b0;
        else if (split_q) done = (t_last || !t_act) && (c_last || !c_act);
        else              done = c_last;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.busy = 1'b1;
            ctl_d.mode = mode_split ? MODE_SPLIT : MODE_COMBINED;
        end else if (done) begin
            ctl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{busy: 1'b0, mode: MODE_COMBINED};
        else        ctl_q <= ctl_d;
    end

    assign busy = ctl_q.busy;

    ser_walker #(.OUTER_N(1), .INNER_N(N_CH), .WORD_W(T_W)) u_twalk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (t_start),
        .active    (t_act),
        .first     (t_first),
        .last      (t_last),
        .outer_idx (t_outer),
        .inner_idx (t_rd_ch),
        .bit_idx   (t_bitc)
    );

    ser_walker #(.OUTER_N(N_SMP), .INNER_N(N_CH), .WORD_W(C_W)) u_cwalk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (c_start),
        .active    (c_act),
        .first     (c_first),
        .last      (c_last),
        .outer_idx (c_rd_smp),
        .inner_idx (c_rd_ch),
        .bit_idx   (c_bitc)
    );

    stream_route u_route (
        .split   (split_q),
        .t_act   (t_act),
        .t_first (t_first),
        .t_bit   (t_rd_data[t_bitc]),
        .c_act   (c_act),
        .c_first (c_first),
        .c_bit   (c_rd_data[c_bitc]),
        .a_sdata (a_sdata),
        .a_valid (a_valid),
        .a_sof   (a_sof),
        .b_sdata (b_sdata),
        .b_valid (b_valid),
        .b_sof   (b_sof)
    );

endmodule

// File: rtl/evt_frame_ser_chk.sv
module evt_frame_ser_chk (
    input logic clk,
    input logic rst_n,
    input logic evt_ready,
    input logic busy,
    input logic a_valid,
    input logic a_sof,
    input logic b_valid,
    input logic b_sof,
    input logic t_act,
    input logic t_outer
);

    assert_sof_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_sof |-> a_valid);

    assert_sof_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_sof |=> !a_sof);

    assert_valid_under_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid || b_valid) |-> busy);

    assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evt_ready) |=> (busy && a_sof));

    assert_busy_ends_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!a_valid && !b_valid));

    assert_busy_ignores_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && evt_ready) |=> (!a_sof && !b_sof));

    assert_split_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        b_sof |-> a_sof);

    assert_timing_single_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t_act |-> (t_outer == 1'b0));

endmodule

bind evt_frame_ser evt_frame_ser_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_ready (evt_ready),
    .busy      (busy),
    .a_valid   (a_valid),
    .a_sof     (a_sof),
    .b_valid   (b_valid),
    .b_sof     (b_sof),
    .t_act     (t_act),
    .t_outer   (t_outer[0])
);

// File: tb/sim_evt_frame_ser.sv
module sim_evt_frame_ser;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 3;
    localparam int TW  = 5;
    localparam int CW  = 4;
    localparam int NS  = 2;
    localparam int TL  = NC * TW;
    localparam int CL  = NS * NC * CW;
    localparam int WIN = TL + CL + 4;
    localparam int CHW = (NC > 1) ? $clog2(NC) : 1;
    localparam int SW  = (NS > 1) ? $clog2(NS) : 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           evt_ready;
    logic           mode_split;
    logic           busy;
    logic [CHW-1:0] t_rd_ch;
    logic [TW-1:0]  t_rd_data;
    logic [CHW-1:0] c_rd_ch;
    logic [SW-1:0]  c_rd_smp;
    logic [CW-1:0]  c_rd_data;
    logic           a_sdata, a_valid, a_sof, b_sdata, b_valid, b_sof;

    int cur_seed = 0;
    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [TW-1:0] tword(input int seed, input int ch);
        return TW'(seed * 29 + ch * 7 + 3);
    endfunction

    function automatic logic [CW-1:0] cword(input int seed, input int smp, input int ch);
        return CW'(seed * 13 + smp * 5 + ch * 3 + 1);
    endfunction

    // Capture storage model: combinational reads.
    always_comb t_rd_data = tword(cur_seed, int'(t_rd_ch));
    always_comb c_rd_data = cword(cur_seed, int'(c_rd_smp), int'(c_rd_ch));

    evt_frame_ser #(.N_CH(NC), .T_W(TW), .C_W(CW), .N_SMP(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_ready(evt_ready), .mode_split(mode_split),
        .busy(busy), .t_rd_ch(t_rd_ch), .t_rd_data(t_rd_data),
        .c_rd_ch(c_rd_ch), .c_rd_smp(c_rd_smp), .c_rd_data(c_rd_data),
        .a_sdata(a_sdata), .a_valid(a_valid), .a_sof(a_sof),
        .b_sdata(b_sdata), .b_valid(b_valid), .b_sof(b_sof)
    );

    // Expected bit i of a timing frame (R2): channel-major, MSB first.
    function automatic logic exp_t(input int seed, input int i);
        logic [TW-1:0] w;
        w = tword(seed, i / TW);
        return w[TW - 1 - (i % TW)];
    endfunction

    // Expected bit j of a charge frame (R3): sample-major, MSB first.
    function automatic logic exp_c(input int seed, input int j);
        int wi;
        logic [CW-1:0] w;
        wi = j / CW;
        w  = cword(seed, wi / NC, wi % NC);
        return w[CW - 1 - (j % CW)];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    typedef struct packed {
        logic        split;
        logic [7:0]  seed;
        logic        disturb;
        logic [15:0] len_a;
        logic [15:0] len_b;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 8'd1, 1'b0, 16'(TL + CL), 16'd0},
        '{1'b1, 8'd2, 1'b0, 16'(TL),      16'(CL)},
        '{1'b0, 8'd7, 1'b1, 16'(TL + CL), 16'd0},
        '{1'b1, 8'd9, 1'b1, 16'(TL),      16'(CL)},
        '{1'b1, 8'd4, 1'b0, 16'(TL),      16'(CL)}
    };

    task automatic run_event(input vec_t v);
        int  a_len, b_len, busy_len, a_err, b_err, a_sofs, b_sofs, gaps;
        bit  a_sof0, b_sof0, a_done, b_done;
        int  exp_busy;
        a_len = 0; b_len = 0; busy_len = 0; a_err = 0; b_err = 0;
        a_sofs = 0; b_sofs = 0; gaps = 0; a_sof0 = 0; b_sof0 = 0;
        a_done = 0; b_done = 0;
        @(negedge clk);
        cur_seed   = int'(v.seed);
        mode_split = v.split;
        evt_ready  = 1'b1;
        @(negedge clk);
        evt_ready = 1'b0;
        // First cycle after the acceptance edge (R7).
        chk(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
        for (int n = 0; n < WIN; n++) begin
            if (busy) busy_len++;
            if (a_valid) begin
                if (a_done) gaps++;
                if (v.split || a_len < TL) begin
                    if (a_sdata !== exp_t(int'(v.seed), a_len)) a_err++;
                end else begin
                    if (a_sdata !== exp_c(int'(v.seed), a_len - TL)) a_err++;
                end
                a_len++;
            end else if (a_len > 0) a_done = 1;
            if (a_sof) begin a_sofs++; if (n == 0) a_sof0 = 1; end
            if (b_valid) begin
                if (b_done) gaps++;
                if (b_sdata !== exp_c(int'(v.seed), b_len)) b_err++;
                b_len++;
            end else if (b_len > 0) b_done = 1;
            if (b_sof) begin b_sofs++; if (n == 0) b_sof0 = 1; end
            // Disturbance during the frame (R8, R9).
            if (v.disturb && n == 3) begin
                evt_ready  = 1'b1;
                mode_split = ~v.split;
            end
            if (v.disturb && n == 4) evt_ready = 1'b0;
            @(negedge clk);
        end
        exp_busy = (int'(v.len_a) > int'(v.len_b)) ? int'(v.len_a) : int'(v.len_b);
        chk(a_len == int'(v.len_a), v.split ? "R5" : "R4", "stream A length", a_len, int'(v.len_a));
        chk(a_err == 0, v.split ? "R2" : "R4", "stream A bit errors", a_err, 0);
        chk(b_len == int'(v.len_b), v.split ? "R5" : "R4", "stream B length", b_len, int'(v.len_b));
        chk(b_err == 0, "R3", "stream B bit errors", b_err, 0);
        chk(a_sofs == 1 && a_sof0, "R6", "stream A sof count", a_sofs, 1);
        chk(b_sofs == (v.split ? 1 : 0) && (b_sof0 == v.split), "R5", "stream B sof count",
            b_sofs, v.split ? 1 : 0);
        chk(gaps == 0, "R6", "valid gaps", gaps, 0);
        chk(busy_len == exp_busy, v.disturb ? "R8" : "R7", "busy cycles", busy_len, exp_busy);
        chk(!busy && !a_valid && !b_valid, v.disturb ? "R9" : "R7", "idle after event",
            int'(busy) + int'(a_valid), 0);
        mode_split = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        report();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        evt_ready  = 1'b0;
        mode_split = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(!busy && !a_valid && !a_sof && !b_valid && !b_sof && !a_sdata && !b_sdata,
            "R1", "outputs in reset", int'(busy) + int'(a_valid) + int'(b_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !a_valid, "R1", "idle after reset release", int'(busy), 0);

        for (int k = 0; k < 5; k++) run_event(VECS[k]);

        // Reset during a split frame (R1), then a fresh combined event.
        @(negedge clk);
        cur_seed = 3; mode_split = 1'b1; evt_ready = 1'b1;
        @(negedge clk);
        evt_ready = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy && a_valid && b_valid, "R5", "both streams mid-frame", int'(a_valid) + int'(b_valid), 2);
        rst_n = 1'b0;
        #1;
        chk(!busy && !a_valid && !b_valid && !a_sof && !b_sof, "R1", "outputs at mid-frame reset",
            int'(busy) + int'(a_valid) + int'(b_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mode_split = 1'b0;
        run_event(VECS[0]);

        report();
        $finish;
    end

endmodule